// File: doc/BRIEF.md
# Quadrature DDS Reference Generator

This core builds the reference for a lock-in amplifier by direct digital synthesis. A single 32-bit phase register is stepped by a tuning word on every clock. One-bit square, signed sine and signed cosine outputs are all derived from that one phase value. Because of this, the three outputs can never drift apart in frequency. The output frequency is `tune * f_clk / 2^32`, so the frequency step is `f_clk / 2^32` and depends on nothing else.

The sine and cosine come from one 1024-entry table that is computed at elaboration. An optional linear interpolation between neighbouring entries lowers phase noise. It does not change the frequency. The square output changes only on clock edges. Its edges fall at exactly the same places every period only when the clock is an integer multiple of the output frequency.

A change to the tuning word is applied on the next clock and does not reset the phase. All outputs leave a three-stage pipeline together, and a valid flag marks when that pipeline holds real data.

Top module: `quad_dds_ref`

## Requirements
- R1: On every clock without reset, the 32-bit phase increases by `tune` modulo 2^32. A new `tune` value applies from the next clock, and the phase carries on from its current value without a jump.
- R2: Synchronous reset sets the phase to 0. `out_valid` is 0 on the clock after any cycle in which `rst` is high.
- R3: `out_valid` goes to 1 on the third rising edge after reset is released, and then stays at 1 until the next reset. The first valid sample belongs to phase 0: `sin_out`=0, `cos_out`=32767, `sq_out`=0.
- R4: Table entry i holds 32767*sin(2*pi*i/1024), rounded to the nearest integer. The table is addressed by phase bits [31:22]. With interpolation off, `sin_out` is the entry at that address.
- R5: `cos_out` is computed in the same way as `sin_out`, using the phase plus 2^30 taken from the same phase value.
- R6: `sq_out` is phase bit 31. It is delayed so that it lines up with the sine and cosine sample from the same phase.
- R7: With interpolation on, each output is e0 + floor((e1-e0)*f/4096). Here e0 is the addressed entry, e1 is the next entry (entry 1023 is followed by entry 0), and f is phase bits [21:10].
- R8: `interp_en` is captured together with the phase it applies to. A change of `interp_en` therefore affects exactly the samples whose phase was captured after the change, three cycles later at the outputs.
- R9: When the tuning word is 2^32/N, `sq_out` rises exactly once every N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tune | input | 32 | Phase increment per clock |
| interp_en | input | 1 | Linear interpolation enable |
| sq_out | output | 1 | Square-wave reference |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| out_valid | output | 1 | Outputs hold pipeline data |

## Verification
The case where two functions meet in one cycle is a tuning-word change on the same clock as a toggle of the interpolation enable. Phase continuity and interpolation selection must then both be correct for the same captured phase. The bench drives both changes on the same edge and keeps a cycle-by-cycle model of phase and enable. A scoreboard compares each queued expectation against the sample that appears three cycles later, which exposes an enable that is misaligned by one cycle or a phase that jumps. The wrap of the accumulator and the wrap of the table index from 1023 to 0 are provoked with a large, negative-stepping tuning word.

// File: rtl/quad_dds_ref.sv
module quad_dds_ref #(
  parameter int PW = 32,
  parameter int AW = 10,
  parameter int FW = 12,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        tune,
  input  logic                 interp_en,
  output logic                 sq_out,
  output logic signed [DW-1:0] sin_out,
  output logic signed [DW-1:0] cos_out,
  output logic                 out_valid
);
  localparam int DEPTH = 1 << AW;
  localparam int AMP = (1 << (DW - 1)) - 1;
  localparam logic [PW-1:0] QTR = PW'(1) << (PW - 2);
  localparam int PRW = DW + FW + 2;

  logic signed [DW-1:0] lut [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real r;
      r = AMP * $sin(2.0 * 3.14159265358979 * i / DEPTH);
      lut[i] = DW'($rtoi(r >= 0.0 ? r + 0.5 : r - 0.5));
    end
  end

  logic [PW-1:0] acc;
  logic [PW-1:0] cph;
  logic [AW-1:0] sa, ca;
  logic [FW-1:0] fr;

  assign cph = acc + QTR;
  assign sa  = acc[PW-1 -: AW];
  assign ca  = cph[PW-1 -: AW];
  assign fr  = acc[PW-AW-1 -: FW];

  logic signed [DW-1:0] s0, s1, c0, c1, s2, c2;
  logic [FW-1:0] fr1;
  logic ie1, ie2, sq1, sq2;
  logic signed [PRW-1:0] ps, pc;
  logic [2:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      vld <= '0;
    end else begin
      acc <= acc + tune;
      vld <= {vld[1:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    s0  <= lut[sa];
    s1  <= lut[sa + AW'(1)];
    c0  <= lut[ca];
    c1  <= lut[ca + AW'(1)];
    fr1 <= fr;
    ie1 <= interp_en;
    sq1 <= acc[PW-1];

    ps  <= ($signed({s1[DW-1], s1}) - $signed({s0[DW-1], s0})) * $signed({1'b0, fr1});
    pc  <= ($signed({c1[DW-1], c1}) - $signed({c0[DW-1], c0})) * $signed({1'b0, fr1});
    s2  <= s0;
    c2  <= c0;
    ie2 <= ie1;
    sq2 <= sq1;

    sin_out <= ie2 ? s2 + DW'(ps >>> FW) : s2;
    cos_out <= ie2 ? c2 + DW'(pc >>> FW) : c2;
    sq_out  <= sq2;
  end

  assign out_valid = vld[2];

  // R1
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc == $past(acc) + $past(tune));

  // R2
  valid_clr_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);

  // R6
  sq_pos_half_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !sq_out) |-> sin_out >= 0);

  // R6
  sq_neg_half_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && sq_out) |-> sin_out <= 0);
endmodule

// File: tb/sim_quad_dds_ref.sv
module sim_quad_dds_ref;
  logic clk = 0;
  logic rst = 1;
  logic [31:0] tune = 0;
  logic interp_en = 0;
  logic sq_out, out_valid;
  logic signed [15:0] sin_out, cos_out;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R4";

  always #5 clk = ~clk;

  quad_dds_ref u0 (.clk(clk), .rst(rst), .tune(tune), .interp_en(interp_en),
                   .sq_out(sq_out), .sin_out(sin_out), .cos_out(cos_out),
                   .out_valid(out_valid));

  int ref_tab [1024];
  initial begin
    for (int i = 0; i < 1024; i++) begin
      real r;
      r = 32767.0 * $sin(2.0 * 3.14159265358979 * i / 1024);
      ref_tab[i] = $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
    end
  end

  function automatic int expect_wave(bit [31:0] ph, bit en);
    int a, e0, e1, f;
    a  = int'(ph[31:22]);
    f  = int'(ph[21:10]);
    e0 = ref_tab[a];
    e1 = ref_tab[(a + 1) % 1024];
    return en ? e0 + (((e1 - e0) * f) >>> 12) : e0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  int qs[$], qc[$];
  bit qq[$], qi[$];
  bit [31:0] mph = 0;

  always @(posedge clk) begin
    if (rst) begin
      mph = 0;
      qs.delete(); qc.delete(); qq.delete(); qi.delete();
    end else begin
      qs.push_back(expect_wave(mph, interp_en));
      qc.push_back(expect_wave(mph + 32'h4000_0000, interp_en));
      qq.push_back(mph[31]);
      qi.push_back(interp_en);
      mph = mph + tune;
    end
  end

  always @(negedge clk) begin
    if (out_valid && !rst) begin
      if (qs.size() == 0) check({tag, " R3 empty queue"}, 1, 0);
      else begin
        int es, ec;
        bit eq, ei;
        es = qs.pop_front(); ec = qc.pop_front();
        eq = qq.pop_front(); ei = qi.pop_front();
        check({tag, ei ? " R7 sin" : " R4 sin"}, int'(sin_out), es);
        check({tag, " R5 cos"}, int'(cos_out), ec);
        check({tag, " R6 sq"}, int'(sq_out), int'(eq));
      end
    end
  end

  task automatic do_reset(bit [31:0] tw, bit en);
    @(negedge clk);
    rst = 1; tune = tw; interp_en = en;
    repeat (3) @(negedge clk);
    check("R2 valid in reset", int'(out_valid), 0);
    rst = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R3: first valid sample and exact timing
    tag = "R3";
    do_reset(32'h0400_0000, 0);
    @(negedge clk); check("R3 valid edge1", int'(out_valid), 0);
    @(negedge clk); check("R3 valid edge2", int'(out_valid), 0);
    @(negedge clk); check("R3 valid edge3", int'(out_valid), 1);
    check("R3 first sin", int'(sin_out), 0);
    check("R3 first cos", int'(cos_out), 32767);
    check("R3 first sq", int'(sq_out), 0);
    tag = "R4";
    repeat (150) @(negedge clk);
    // R1 R8: tuning change and interp toggle on the same edge
    tag = "R1 R8";
    tune = 32'h0123_4567; interp_en = 1;
    repeat (200) @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      tune = 32'h00F0_1234 + 32'(k * 32'h0001_1111);
      if (k % 3 == 0) interp_en = ~interp_en;
      @(negedge clk);
    end
    // R7: backward stepping across the 2^32 and table wrap
    tag = "R7 wrap";
    interp_en = 1; tune = 32'hFFF0_0321;
    repeat (400) @(negedge clk);
    interp_en = 0; tune = 32'hFFC0_0000;
    repeat (100) @(negedge clk);
    // R2: mid-run reset
    tag = "R2";
    do_reset(32'h0400_0000, 0);
    // R9: jitter-free period of 64 cycles
    tag = "R9";
    begin
      int cyc = 0, last = -1, seen = 0;
      bit prev = 0;
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        cyc++;
        if (out_valid) begin
          if (sq_out && !prev) begin
            if (last >= 0) check("R9 square period", cyc - last, 64);
            last = cyc; seen++;
          end
          prev = sq_out;
        end
      end
      check("R9 rising edges seen", int'(seen >= 5), 1);
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule